// File: doc/BRIEF.md
# Byte/Pair Register Bank for an 8-bit Processor

This block holds the register state a program sees on a small 8-bit processor. It has an accumulator and six general byte registers, a 16-bit stack pointer, a 16-bit program counter and a carry flag. The six general registers can also be used in fixed couples as three 16-bit pairs. A decoder drives two kinds of request each cycle. The first is a byte write selected by a 3-bit register code. The second is a pair operation selected by a 3-bit operation code and a 2-bit pair code. Both may be issued in the same cycle.

Two byte read ports return register contents combinationally. The current H:L value is always driven out as the address of the memory operand. That operand uses register code 110, which names no storage here. The 16-bit add into H:L is the only operation in this block that touches the carry flag. All control pins are plain level signals: every request is taken at the next rising clock edge, and the block never stalls.

Top module: `cpu_regfile`

## Requirements
- R1: While `rst_n` is low and after it is released, PC, SP, the carry flag and every byte register read as zero.
- R2: A byte write (`wr_en`=1) stores `wr_data` at the next edge into the register given by `wr_sel`, with codes B=000, C=001, D=010, E=011, H=100, L=101, A=111. Both read ports return the stored value combinationally for the code on their select input.
- R3: A byte write with code 110 changes no register. Reading code 110 returns 00h. `hl_ptr` always equals {H,L}.
- R4: Pair codes are BC=00, DE=01, HL=10 and SP=11. For the byte pairs, the first-named register holds bits 15:8.
- R5: Pair operation codes are 0 none, 1 load, 2 increment, 3 decrement, 4 add-to-HL, 5 exchange, 6 HL-to-SP and 7 HL-to-PC. Load writes `pair_imm` into the selected pair and leaves the carry flag unchanged.
- R6: Increment and decrement of the selected pair wrap modulo 65536 and leave the carry flag unchanged.
- R7: Add-to-HL writes H:L plus the selected pair into H:L and writes bit 16 of the sum into the carry flag. No other operation changes the carry flag.
- R8: Add-to-HL with the HL code shifts H:L left by one bit, and the bit shifted out goes to carry.
- R9: Exchange swaps D:E with H:L in a single edge.
- R10: HL-to-SP copies H:L into SP, and HL-to-PC copies H:L into PC. PC changes on no other operation.
- R11: When a byte write and a pair operation target the same register in one cycle, the pair result is stored. A byte write to any other register in that cycle still lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Byte write request |
| wr_sel | input | 3 | Byte register code for the write |
| wr_data | input | 8 | Byte write data |
| rd_sel_a | input | 3 | Byte register code, read port A |
| rd_data_a | output | 8 | Read port A data |
| rd_sel_b | input | 3 | Byte register code, read port B |
| rd_data_b | output | 8 | Read port B data |
| pair_op | input | 3 | Pair operation code |
| pair_sel | input | 2 | Pair code |
| pair_imm | input | 16 | Immediate value for pair load |
| hl_ptr | output | 16 | Current H:L, address of the memory operand |
| sp_out | output | 16 | Stack pointer |
| pc_out | output | 16 | Program counter |
| carry_out | output | 1 | Carry flag |

## Verification
Every write, whether byte or pair, becomes visible exactly one rising edge after it is presented. The read ports, `hl_ptr`, `sp_out`, `pc_out` and `carry_out` are direct views of storage, so they show no extra delay. The bench changes inputs on the falling edge and lets one rising edge pass. It then samples on the following falling edge, first settling each read select for a short delay. In-RTL properties check the one-edge latency of exchange, shift, increment and byte writes against the values from the previous edge.

// File: rtl/rf_pkg.sv
package rf_pkg;

  typedef enum logic [2:0] {
    PO_NONE  = 3'd0,
    PO_LOAD  = 3'd1,
    PO_INC   = 3'd2,
    PO_DEC   = 3'd3,
    PO_ADD   = 3'd4,
    PO_SWAP  = 3'd5,
    PO_HL2SP = 3'd6,
    PO_HL2PC = 3'd7
  } pair_op_e;

  localparam int NUM_CODES = 8;

  localparam logic [2:0] RC_D = 3'b010;
  localparam logic [2:0] RC_E = 3'b011;
  localparam logic [2:0] RC_H = 3'b100;
  localparam logic [2:0] RC_L = 3'b101;
  localparam logic [2:0] RC_M = 3'b110;
  localparam logic [2:0] RC_A = 3'b111;

  localparam logic [1:0] PS_HL = 2'b10;
  localparam logic [1:0] PS_SP = 2'b11;

endpackage

// File: rtl/rf_pair_unit.sv
module rf_pair_unit
  import rf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  pair_op_e                               op,
  input  logic [1:0]                             sel,
  input  logic [2*DATA_W-1:0]                    imm,
  input  logic [NUM_CODES-1:0][DATA_W-1:0]       bank_q,
  input  logic [2*DATA_W-1:0]                    sp_q,
  output logic [NUM_CODES-1:0]                   pw_we,
  output logic [NUM_CODES-1:0][DATA_W-1:0]       pw_d,
  output logic                                   sp_we,
  output logic [2*DATA_W-1:0]                    sp_d,
  output logic                                   pc_we,
  output logic [2*DATA_W-1:0]                    pc_d,
  output logic                                   cy_we,
  output logic                                   cy_d
);

  localparam int PW = 2 * DATA_W;

  logic [PW-1:0] src, hl, de, res;
  logic [PW:0]   sum;
  logic          dest_we, hl_we;

  assign hl  = {bank_q[RC_H], bank_q[RC_L]};
  assign de  = {bank_q[RC_D], bank_q[RC_E]};
  assign src = (sel == PS_SP) ? sp_q : {bank_q[{sel, 1'b0}], bank_q[{sel, 1'b1}]};
  assign sum = {1'b0, hl} + {1'b0, src};

  always_comb begin
    pw_we   = '0;
    pw_d    = '0;
    sp_we   = 1'b0;
    sp_d    = '0;
    pc_we   = 1'b0;
    pc_d    = '0;
    cy_we   = 1'b0;
    cy_d    = 1'b0;
    res     = '0;
    dest_we = 1'b0;
    hl_we   = 1'b0;
    unique case (op)
      PO_LOAD: begin res = imm;              dest_we = 1'b1; end
      PO_INC:  begin res = src + PW'(1);     dest_we = 1'b1; end
      PO_DEC:  begin res = src - PW'(1);     dest_we = 1'b1; end
      PO_ADD: begin
        res   = sum[PW-1:0];
        hl_we = 1'b1;
        cy_we = 1'b1;
        cy_d  = sum[PW];
      end
      PO_SWAP: begin
        pw_we[RC_D] = 1'b1; pw_d[RC_D] = hl[PW-1:DATA_W];
        pw_we[RC_E] = 1'b1; pw_d[RC_E] = hl[DATA_W-1:0];
        pw_we[RC_H] = 1'b1; pw_d[RC_H] = de[PW-1:DATA_W];
        pw_we[RC_L] = 1'b1; pw_d[RC_L] = de[DATA_W-1:0];
      end
      PO_HL2SP: begin sp_we = 1'b1; sp_d = hl; end
      PO_HL2PC: begin pc_we = 1'b1; pc_d = hl; end
      default: ;
    endcase
    if (dest_we) begin
      if (sel == PS_SP) begin
        sp_we = 1'b1;
        sp_d  = res;
      end else begin
        pw_we[{sel, 1'b0}] = 1'b1;
        pw_d[{sel, 1'b0}]  = res[PW-1:DATA_W];
        pw_we[{sel, 1'b1}] = 1'b1;
        pw_d[{sel, 1'b1}]  = res[DATA_W-1:0];
      end
    end
    if (hl_we) begin
      pw_we[RC_H] = 1'b1; pw_d[RC_H] = res[PW-1:DATA_W];
      pw_we[RC_L] = 1'b1; pw_d[RC_L] = res[DATA_W-1:0];
    end
  end

  always_comb begin
    AST_M_NOT_PAIRED: assert (pw_we[RC_M] == 1'b0); // R3
  end

endmodule

// File: rtl/rf_byte_bank.sv
module rf_byte_bank
  import rf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [2:0]                       wr_sel,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic [NUM_CODES-1:0]             pw_we,
  input  logic [NUM_CODES-1:0][DATA_W-1:0] pw_d,
  output logic [NUM_CODES-1:0][DATA_W-1:0] q
);

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_reg
    if (g == int'(RC_M)) begin : g_mem_slot
      assign q[g] = '0;
    end else begin : g_store
      logic [DATA_W-1:0] r;
      logic              byte_hit;
      assign byte_hit = wr_en && (wr_sel == 3'(g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        r <= '0;
        else if (pw_we[g]) r <= pw_d[g];
        else if (byte_hit) r <= wr_data;
      end
      assign q[g] = r;

      AST_BYTE_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_hit && !pw_we[g]) |=> (q[g] == $past(wr_data))); // R2
      AST_PAIR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        pw_we[g] |=> (q[g] == $past(pw_d[g]))); // R11
    end
  end

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import rf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [2:0]            wr_sel,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [2:0]            rd_sel_a,
  output logic [DATA_W-1:0]     rd_data_a,
  input  logic [2:0]            rd_sel_b,
  output logic [DATA_W-1:0]     rd_data_b,
  input  logic [2:0]            pair_op,
  input  logic [1:0]            pair_sel,
  input  logic [2*DATA_W-1:0]   pair_imm,
  output logic [2*DATA_W-1:0]   hl_ptr,
  output logic [2*DATA_W-1:0]   sp_out,
  output logic [2*DATA_W-1:0]   pc_out,
  output logic                  carry_out
);

  localparam int PW = 2 * DATA_W;

  pair_op_e                         op;
  logic [NUM_CODES-1:0][DATA_W-1:0] bank_q;
  logic [NUM_CODES-1:0]             pw_we;
  logic [NUM_CODES-1:0][DATA_W-1:0] pw_d;
  logic                             sp_we, pc_we, cy_we, cy_d;
  logic [PW-1:0]                    sp_d, pc_d, sp_q, pc_q, de_q;
  logic                             cy_q;

  assign op = pair_op_e'(pair_op);

  rf_pair_unit #(.DATA_W(DATA_W)) u_pair (
    .op(op), .sel(pair_sel), .imm(pair_imm), .bank_q(bank_q), .sp_q(sp_q),
    .pw_we(pw_we), .pw_d(pw_d), .sp_we(sp_we), .sp_d(sp_d),
    .pc_we(pc_we), .pc_d(pc_d), .cy_we(cy_we), .cy_d(cy_d)
  );

  rf_byte_bank #(.DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .pw_we(pw_we), .pw_d(pw_d), .q(bank_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
      pc_q <= '0;
      cy_q <= 1'b0;
    end else begin
      if (sp_we) sp_q <= sp_d;
      if (pc_we) pc_q <= pc_d;
      if (cy_we) cy_q <= cy_d;
    end
  end

  assign rd_data_a = bank_q[rd_sel_a];
  assign rd_data_b = bank_q[rd_sel_b];
  assign hl_ptr    = {bank_q[RC_H], bank_q[RC_L]};
  assign de_q      = {bank_q[RC_D], bank_q[RC_E]};
  assign sp_out    = sp_q;
  assign pc_out    = pc_q;
  assign carry_out = cy_q;

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op != PO_HL2PC) |=> $stable(pc_q)); // R10
  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op != PO_ADD) |=> $stable(cy_q)); // R7
  AST_SWAP_HL: assert property (@(posedge clk) disable iff (!rst_n)
    (op == PO_SWAP) |=> (hl_ptr == $past(de_q))); // R9
  AST_SWAP_DE: assert property (@(posedge clk) disable iff (!rst_n)
    (op == PO_SWAP) |=> (de_q == $past(hl_ptr))); // R9
  AST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (op == PO_ADD && pair_sel == PS_HL) |=>
      ({cy_q, hl_ptr} == {$past(hl_ptr), 1'b0})); // R8
  AST_SP_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (op == PO_INC && pair_sel == PS_SP) |=> (sp_q == $past(sp_q) + PW'(1))); // R6

endmodule

// File: tb/tb_cpu_regfile.sv
module tb_cpu_regfile;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [7:0]  wr_data;
  logic [2:0]  rd_sel_a, rd_sel_b;
  logic [7:0]  rd_data_a, rd_data_b;
  logic [2:0]  pair_op;
  logic [1:0]  pair_sel;
  logic [15:0] pair_imm;
  logic [15:0] hl_ptr, sp_out, pc_out;
  logic        carry_out;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  cpu_regfile dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel_a(rd_sel_a), .rd_data_a(rd_data_a), .rd_sel_b(rd_sel_b), .rd_data_b(rd_data_b),
    .pair_op(pair_op), .pair_sel(pair_sel), .pair_imm(pair_imm),
    .hl_ptr(hl_ptr), .sp_out(sp_out), .pc_out(pc_out), .carry_out(carry_out)
  );

  task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] code, output logic [7:0] v);
    rd_sel_a = code;
    #1;
    v = rd_data_a;
  endtask

  task automatic getp(input logic [1:0] p, output logic [15:0] v);
    if (p == 2'b11) v = sp_out;
    else begin
      rd_sel_a = {p, 1'b0};
      rd_sel_b = {p, 1'b1};
      #1;
      v = {rd_data_a, rd_data_b};
    end
  endtask

  // one rising edge with the given requests; returns on the next falling edge
  task automatic step(input logic we, input logic [2:0] ws, input logic [7:0] wd,
                      input logic [2:0] op, input logic [1:0] ps, input logic [15:0] imm);
    wr_en = we; wr_sel = ws; wr_data = wd;
    pair_op = op; pair_sel = ps; pair_imm = imm;
    @(negedge clk);
    wr_en = 1'b0; pair_op = 3'd0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1", "pc", pc_out, 16'h0000);
    chk("R1", "sp", sp_out, 16'h0000);
    chk("R1", "carry", {15'd0, carry_out}, 16'h0000);
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), v);
      chk("R1", "byte reg", {8'd0, v}, 16'h0000);
    end
  endtask

  task automatic t_byte_rw;
    logic [7:0] v;
    for (int i = 0; i < 8; i++) if (i != 6) step(1'b1, 3'(i), 8'(8'h10 + i), 3'd0, 2'd0, 16'h0);
    for (int i = 0; i < 8; i++) if (i != 6) begin
      rd(3'(i), v);
      chk("R2", "byte readback", {8'd0, v}, {8'd0, 8'(8'h10 + i)});
    end
    rd_sel_b = 3'b111; #1;
    chk("R2", "port b A", {8'd0, rd_data_b}, 16'h0017);
  endtask

  task automatic t_mem_code;
    logic [7:0] v;
    step(1'b1, 3'b110, 8'hEE, 3'd0, 2'd0, 16'h0);
    for (int i = 0; i < 8; i++) if (i != 6) begin
      rd(3'(i), v);
      chk("R3", "untouched by code 110", {8'd0, v}, {8'd0, 8'(8'h10 + i)});
    end
    rd(3'b110, v);
    chk("R3", "read code 110", {8'd0, v}, 16'h0000);
    chk("R3", "hl_ptr", hl_ptr, 16'h1415);
  endtask

  task automatic t_load;
    logic [15:0] v;
    step(1'b0, 3'd0, 8'h0, 3'd1, 2'd0, 16'h1234);
    step(1'b0, 3'd0, 8'h0, 3'd1, 2'd1, 16'h5678);
    step(1'b0, 3'd0, 8'h0, 3'd1, 2'd2, 16'h9ABC);
    step(1'b0, 3'd0, 8'h0, 3'd1, 2'd3, 16'hDEF0);
    getp(2'd0, v); chk("R4", "BC load order", v, 16'h1234);
    getp(2'd1, v); chk("R5", "DE load", v, 16'h5678);
    getp(2'd2, v); chk("R5", "HL load", v, 16'h9ABC);
    chk("R5", "SP load", sp_out, 16'hDEF0);
    chk("R3", "hl_ptr after load", hl_ptr, 16'h9ABC);
    chk("R5", "carry untouched by load", {15'd0, carry_out}, 16'h0000);
  endtask

  task automatic t_add;
    step(1'b0, 3'd0, 8'h0, 3'd4, 2'd1, 16'h0);
    chk("R7", "HL+DE", hl_ptr, 16'hF134);
    chk("R7", "carry clear", {15'd0, carry_out}, 16'h0000);
    step(1'b0, 3'd0, 8'h0, 3'd4, 2'd0, 16'h0);
    chk("R7", "HL+BC wrap", hl_ptr, 16'h0368);
    chk("R7", "carry set", {15'd0, carry_out}, 16'h0001);
    step(1'b0, 3'd0, 8'h0, 3'd4, 2'd3, 16'h0);
    chk("R7", "HL+SP", hl_ptr, 16'hE258);
    chk("R7", "carry from HL+SP", {15'd0, carry_out}, 16'h0000);
  endtask

  task automatic t_shift;
    step(1'b0, 3'd0, 8'h0, 3'd1, 2'd2, 16'h8001);
    step(1'b0, 3'd0, 8'h0, 3'd4, 2'd2, 16'h0);
    chk("R8", "shift 8001", hl_ptr, 16'h0002);
    chk("R8", "shift-out 1", {15'd0, carry_out}, 16'h0001);
    step(1'b0, 3'd0, 8'h0, 3'd1, 2'd2, 16'h4000);
    step(1'b0, 3'd0, 8'h0, 3'd4, 2'd2, 16'h0);
    chk("R8", "shift 4000", hl_ptr, 16'h8000);
    chk("R8", "shift-out 0", {15'd0, carry_out}, 16'h0000);
    step(1'b0, 3'd0, 8'h0, 3'd4, 2'd2, 16'h0);
    chk("R8", "shift 8000", hl_ptr, 16'h0000);
    chk("R8", "shift-out 1 again", {15'd0, carry_out}, 16'h0001);
  endtask

  task automatic t_incdec;
    logic [15:0] v;
    step(1'b0, 3'd0, 8'h0, 3'd1, 2'd3, 16'hFFFF);
    step(1'b0, 3'd0, 8'h0, 3'd2, 2'd3, 16'h0);
    chk("R6", "SP inc wrap", sp_out, 16'h0000);
    step(1'b0, 3'd0, 8'h0, 3'd3, 2'd3, 16'h0);
    chk("R6", "SP dec wrap", sp_out, 16'hFFFF);
    step(1'b0, 3'd0, 8'h0, 3'd1, 2'd0, 16'h0000);
    step(1'b0, 3'd0, 8'h0, 3'd3, 2'd0, 16'h0);
    getp(2'd0, v); chk("R6", "BC dec wrap", v, 16'hFFFF);
    step(1'b0, 3'd0, 8'h0, 3'd1, 2'd1, 16'h00FF);
    step(1'b0, 3'd0, 8'h0, 3'd2, 2'd1, 16'h0);
    getp(2'd1, v); chk("R6", "DE inc byte carry", v, 16'h0100);
    chk("R6", "carry kept", {15'd0, carry_out}, 16'h0001);
  endtask

  task automatic t_swap;
    logic [15:0] v;
    step(1'b0, 3'd0, 8'h0, 3'd1, 2'd1, 16'h1111);
    step(1'b0, 3'd0, 8'h0, 3'd1, 2'd2, 16'h2222);
    step(1'b0, 3'd0, 8'h0, 3'd5, 2'd0, 16'h0);
    getp(2'd1, v); chk("R9", "DE after swap", v, 16'h2222);
    getp(2'd2, v); chk("R9", "HL after swap", v, 16'h1111);
  endtask

  task automatic t_copy;
    step(1'b0, 3'd0, 8'h0, 3'd6, 2'd0, 16'h0);
    chk("R10", "HL to SP", sp_out, 16'h1111);
    chk("R10", "PC unchanged", pc_out, 16'h0000);
    step(1'b0, 3'd0, 8'h0, 3'd7, 2'd0, 16'h0);
    chk("R10", "HL to PC", pc_out, 16'h1111);
    chk("R10", "SP unchanged", sp_out, 16'h1111);
  endtask

  task automatic t_collide;
    logic [15:0] v;
    logic [7:0]  b;
    step(1'b1, 3'b100, 8'h55, 3'd1, 2'd2, 16'hABCD);
    getp(2'd2, v); chk("R11", "pair beats byte on H", v, 16'hABCD);
    step(1'b1, 3'b111, 8'h77, 3'd1, 2'd0, 16'h0102);
    rd(3'b111, b); chk("R11", "A written alongside load", {8'd0, b}, 16'h0077);
    getp(2'd0, v); chk("R11", "BC load alongside", v, 16'h0102);
    step(1'b1, 3'b011, 8'h99, 3'd5, 2'd0, 16'h0);
    getp(2'd1, v); chk("R11", "swap beats byte on E", v, 16'hABCD);
    getp(2'd2, v); chk("R11", "HL after swap+write", v, 16'h2222);
  endtask

  initial begin
    #200000000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    rd_sel_a = '0; rd_sel_b = '0; pair_op = '0; pair_sel = '0; pair_imm = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_byte_rw;
    t_mem_code;
    t_load;
    t_add;
    t_shift;
    t_incdec;
    t_swap;
    t_copy;
    t_collide;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule